// File: doc/BRIEF.md
# Precise Exception Controller

This block is the exception logic of a five-stage in-order pipeline with the stages fetch, decode, execute, memory and writeback. Three stages can raise a fault. The decode stage flags an undefined opcode. The execute stage flags an arithmetic overflow. The memory stage flags a bad data access. A fault is not acted on when it is detected. It is stored as a pending code in a shadow copy of the pipeline registers, next to the instruction's PC, and moves forward with that instruction. Because the PC travels with the fault, the PC recorded for the handler is the PC of the offending instruction and not the fetch address, which has moved on by then.

A fault is taken when its instruction is in the memory stage. At that point every older instruction has already left for writeback and completes normally. In the same cycle the controller pulses a redirect strobe with a handler address, raises a flush for fetch, decode and execute, and squashes the memory-stage instruction so that it neither writes memory nor writes back. On the next clock edge it latches the faulting PC into the exception-PC register and sets one sticky bit in the cause register. The handler address is taken from a vector table that is indexed by the fault type.

The redirect and the flush are plain control pulses that cannot be stalled. They have no handshake and allow no back-pressure, because the pipeline must act on them in the cycle they are raised. The pipeline is assumed to advance every cycle. A cause bit is cleared only by pulsing the matching bit of `cause_clr`.

Top module: `precise_exc_ctrl`

## Requirements
- R1: After reset, `redirect_vld`, `flush_front` and `mem_squash` are low, `epc` is 0 and `cause` is 0.
- R2: An undefined opcode flagged with a valid decode-stage instruction is taken two cycles later, when that instruction is in memory. `redirect_pc` is 0xC0000000, and `cause` bit 2 is set on the following edge.
- R3: An overflow flagged in execute is taken in the next cycle with `redirect_pc` 0xC0000020, and `cause` bit 5 is set on the following edge.
- R4: A data-access fault flagged in memory is taken in the same cycle with `redirect_pc` 0xC0000040, and `cause` bit 4 is set on the following edge.
- R5: When the memory-stage instruction is taken, the younger instructions in decode and execute are flushed. Faults that are pending on them or flagged in that cycle never produce a redirect, and the cause bits they would have set stay clear.
- R6: When one instruction is flagged in several stages, the earliest detection wins. Undefined beats overflow, and overflow beats a memory fault.
- R7: `redirect_vld`, `flush_front` and `mem_squash` rise together and stay high for exactly one cycle per taken fault.
- R8: A fault flag raised for an empty stage has no effect. This covers `id_undef` with `id_vld` low, and an overflow or memory flag while that stage holds no valid instruction.
- R9: Cause bits are sticky and accumulate. A `cause_clr` bit clears its cause bit on the next edge. A bit that is being set in the same cycle stays set.
- R10: `epc` takes the PC of the taken instruction, as presented with it in decode, on the edge after the redirect, and holds its value until the next taken fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_vld | input | 1 | Decode stage holds a valid instruction |
| id_pc | input | 32 | PC of the decode-stage instruction |
| id_undef | input | 1 | Decode-stage instruction has an undefined opcode |
| ex_ovf | input | 1 | Execute-stage instruction overflowed |
| mem_fault | input | 1 | Memory-stage instruction made a bad data access |
| cause_clr | input | 8 | Per-bit clear of the cause register |
| redirect_vld | output | 1 | One-cycle strobe: fetch the handler next cycle |
| redirect_pc | output | 32 | Handler address; valid only with the strobe |
| flush_front | output | 1 | Kill the fetch, decode and execute instructions |
| mem_squash | output | 1 | Suppress the memory write and writeback of the memory-stage instruction |
| epc | output | 32 | PC of the last taken faulting instruction |
| cause | output | 8 | Sticky cause bits: 2 undefined, 4 memory fault, 5 overflow |

## Verification
Directed sequences first send a single fault of each type, so that each one is seen at its own latency and with its own handler address. They then send one instruction that carries all three flags, which isolates the rule that the earliest detection wins. A faulting older instruction followed by two younger faulting ones shows that flushed work is discarded. Flags raised on empty stages show that bubbles are ignored. A long run with a fixed seed then mixes dense back-to-back faults with random cause clears, which exercises the case of a set and a clear on the same cause bit. All of this is compared each cycle against a reference model of the pipeline kept in the bench.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_UNDEF = 2'd1,
    EXC_OVF   = 2'd2,
    EXC_MEMF  = 2'd3
  } exc_code_e;

  // fault type detected by pipeline stage k (0 decode, 1 execute, 2 memory)
  function automatic exc_code_e stage_code(input int k);
    case (k)
      0:       return EXC_UNDEF;
      1:       return EXC_OVF;
      default: return EXC_MEMF;
    endcase
  endfunction

  // an earlier pending fault always wins over a new detection
  function automatic exc_code_e merge_code(input exc_code_e pend, input logic flag,
                                           input exc_code_e fresh);
    if (pend != EXC_NONE) return pend;
    return flag ? fresh : EXC_NONE;
  endfunction
endpackage

// File: rtl/exc_slot.sv
`timescale 1ns/1ps
module exc_slot
  import exc_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            kill,
  input  logic            in_vld,
  input  logic [PC_W-1:0] in_pc,
  input  exc_code_e       in_code,
  output logic            out_vld,
  output logic [PC_W-1:0] out_pc,
  output exc_code_e       out_code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_pc   <= '0;
      out_code <= EXC_NONE;
    end else if (kill) begin
      out_vld  <= 1'b0;
      out_code <= EXC_NONE;
    end else begin
      out_vld  <= in_vld;
      out_pc   <= in_pc;
      out_code <= in_vld ? in_code : EXC_NONE;
    end
  end
endmodule

// File: rtl/exc_vector.sv
`timescale 1ns/1ps
module exc_vector
  import exc_pkg::*;
#(
  parameter int unsigned     PC_W       = 32,
  parameter int unsigned     CAUSE_W    = 8,
  parameter logic [PC_W-1:0] VEC_BASE   = 32'hC000_0000,
  parameter logic [PC_W-1:0] VEC_STRIDE = 32'h0000_0020,
  parameter int unsigned     UNDEF_BIT  = 2,
  parameter int unsigned     MEMF_BIT   = 4,
  parameter int unsigned     OVF_BIT    = 5
) (
  input  exc_code_e          code,
  output logic [PC_W-1:0]    vec,
  output logic [CAUSE_W-1:0] set_mask
);
  logic [1:0] idx;

  always_comb begin
    idx      = 2'(code) - 2'd1;
    vec      = VEC_BASE + PC_W'(idx) * VEC_STRIDE;
    set_mask = '0;
    case (code)
      EXC_UNDEF: set_mask[UNDEF_BIT] = 1'b1;
      EXC_OVF:   set_mask[OVF_BIT]   = 1'b1;
      EXC_MEMF:  set_mask[MEMF_BIT]  = 1'b1;
      default:   set_mask            = '0;
    endcase
  end
endmodule

// File: rtl/exc_status.sv
`timescale 1ns/1ps
module exc_status #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned CAUSE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [PC_W-1:0]    take_pc,
  input  logic [CAUSE_W-1:0] set_mask,
  input  logic [CAUSE_W-1:0] clr_mask,
  output logic [PC_W-1:0]    epc,
  output logic [CAUSE_W-1:0] cause
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc   <= '0;
      cause <= '0;
    end else begin
      if (take) epc <= take_pc;
      cause <= (cause & ~clr_mask) | (take ? set_mask : '0);
    end
  end
endmodule

// File: rtl/precise_exc_ctrl.sv
`timescale 1ns/1ps
module precise_exc_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned     PC_W       = 32,
  parameter int unsigned     CAUSE_W    = 8,
  parameter logic [PC_W-1:0] VEC_BASE   = 32'hC000_0000,
  parameter logic [PC_W-1:0] VEC_STRIDE = 32'h0000_0020,
  parameter int unsigned     UNDEF_BIT  = 2,
  parameter int unsigned     MEMF_BIT   = 4,
  parameter int unsigned     OVF_BIT    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               id_vld,
  input  logic [PC_W-1:0]    id_pc,
  input  logic               id_undef,
  input  logic               ex_ovf,
  input  logic               mem_fault,
  input  logic [CAUSE_W-1:0] cause_clr,
  output logic               redirect_vld,
  output logic [PC_W-1:0]    redirect_pc,
  output logic               flush_front,
  output logic               mem_squash,
  output logic [PC_W-1:0]    epc,
  output logic [CAUSE_W-1:0] cause
);
  localparam int unsigned NSTAGE = 3;  // decode, execute, memory
  localparam int unsigned LAST   = NSTAGE - 1;

  logic            st_vld  [NSTAGE];
  logic [PC_W-1:0] st_pc   [NSTAGE];
  exc_code_e       st_code [NSTAGE];
  exc_code_e       merged  [NSTAGE];
  logic            det     [NSTAGE];
  logic            take;
  logic [CAUSE_W-1:0] set_mask;

  assign st_vld[0]  = id_vld;
  assign st_pc[0]   = id_pc;
  assign st_code[0] = EXC_NONE;
  assign det[0]     = id_undef;
  assign det[1]     = ex_ovf;
  assign det[2]     = mem_fault;

  always_comb begin
    for (int k = 0; k < NSTAGE; k++)
      merged[k] = merge_code(st_code[k], st_vld[k] & det[k], stage_code(k));
  end

  for (genvar k = 0; k < LAST; k++) begin : g_slot
    exc_slot #(.PC_W(PC_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .kill     (take),
      .in_vld   (st_vld[k]),
      .in_pc    (st_pc[k]),
      .in_code  (merged[k]),
      .out_vld  (st_vld[k+1]),
      .out_pc   (st_pc[k+1]),
      .out_code (st_code[k+1])
    );
  end

  assign take = st_vld[LAST] && (merged[LAST] != EXC_NONE);

  exc_vector #(
    .PC_W(PC_W), .CAUSE_W(CAUSE_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE),
    .UNDEF_BIT(UNDEF_BIT), .MEMF_BIT(MEMF_BIT), .OVF_BIT(OVF_BIT)
  ) u_vec (
    .code     (merged[LAST]),
    .vec      (redirect_pc),
    .set_mask (set_mask)
  );

  exc_status #(.PC_W(PC_W), .CAUSE_W(CAUSE_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .take_pc  (st_pc[LAST]),
    .set_mask (set_mask),
    .clr_mask (cause_clr),
    .epc      (epc),
    .cause    (cause)
  );

  assign redirect_vld = take;
  assign flush_front  = take;
  assign mem_squash   = take;
endmodule

// File: rtl/exc_ctrl_chk.sv
`timescale 1ns/1ps
module exc_ctrl_chk #(
  parameter int unsigned     PC_W       = 32,
  parameter int unsigned     CAUSE_W    = 8,
  parameter logic [PC_W-1:0] VEC_BASE   = 32'hC000_0000,
  parameter logic [PC_W-1:0] VEC_STRIDE = 32'h0000_0020,
  parameter int unsigned     UNDEF_BIT  = 2,
  parameter int unsigned     MEMF_BIT   = 4,
  parameter int unsigned     OVF_BIT    = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CAUSE_W-1:0] cause_clr,
  input logic               redirect_vld,
  input logic [PC_W-1:0]    redirect_pc,
  input logic               flush_front,
  input logic               mem_squash,
  input logic [PC_W-1:0]    epc,
  input logic [CAUSE_W-1:0] cause
);
  localparam logic [PC_W-1:0] V_UNDEF = VEC_BASE;
  localparam logic [PC_W-1:0] V_OVF   = VEC_BASE + VEC_STRIDE;
  localparam logic [PC_W-1:0] V_MEMF  = VEC_BASE + 2 * VEC_STRIDE;

  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vld |=> !redirect_vld && !flush_front && !mem_squash);

  a_r2_undef_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_vld && redirect_pc == V_UNDEF) |=> cause[UNDEF_BIT]);

  a_r3_ovf_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_vld && redirect_pc == V_OVF) |=> cause[OVF_BIT]);

  a_r4_memf_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_vld && redirect_pc == V_MEMF) |=> cause[MEMF_BIT]);

  a_r4_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vld |-> (redirect_pc == V_UNDEF || redirect_pc == V_OVF || redirect_pc == V_MEMF));

  a_r10_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_vld |=> $stable(epc));

  for (genvar i = 0; i < CAUSE_W; i++) begin : g_sticky
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (cause[i] && !cause_clr[i]) |=> cause[i]);
  end
endmodule

bind precise_exc_ctrl exc_ctrl_chk #(
  .PC_W(PC_W), .CAUSE_W(CAUSE_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE),
  .UNDEF_BIT(UNDEF_BIT), .MEMF_BIT(MEMF_BIT), .OVF_BIT(OVF_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cause_clr    (cause_clr),
  .redirect_vld (redirect_vld),
  .redirect_pc  (redirect_pc),
  .flush_front  (flush_front),
  .mem_squash   (mem_squash),
  .epc          (epc),
  .cause        (cause)
);

// File: tb/sim_precise_exc_ctrl.sv
`timescale 1ns/1ps
module sim_precise_exc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_vld = 1'b0;
  logic [31:0] id_pc = '0;
  logic        id_undef = 1'b0;
  logic        ex_ovf = 1'b0;
  logic        mem_fault = 1'b0;
  logic [7:0]  cause_clr = '0;
  logic        redirect_vld, flush_front, mem_squash;
  logic [31:0] redirect_pc, epc;
  logic [7:0]  cause;

  int checks = 0;
  int bad = 0;
  int takes = 0;
  string ctx = "";

  // reference model: slot 0 = execute, slot 1 = memory; code 0 none,1 undef,2 ovf,3 memf
  logic        m_vld [2];
  logic [31:0] m_pc  [2];
  int          m_code[2];
  logic [31:0] m_epc;
  logic [7:0]  m_cause;

  always #2.5 clk = ~clk;

  precise_exc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .id_vld(id_vld), .id_pc(id_pc), .id_undef(id_undef),
    .ex_ovf(ex_ovf), .mem_fault(mem_fault), .cause_clr(cause_clr),
    .redirect_vld(redirect_vld), .redirect_pc(redirect_pc), .flush_front(flush_front),
    .mem_squash(mem_squash), .epc(epc), .cause(cause)
  );

  function automatic logic [31:0] vec_of(input int c);
    return 32'hC000_0000 + 32'(c - 1) * 32'h20;
  endfunction

  function automatic logic [7:0] bit_of(input int c);
    case (c)
      1: return 8'h04;
      2: return 8'h20;
      3: return 8'h10;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s [%s]: got %h expected %h", req, what, ctx, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] pc, input logic und,
                      input logic ovf, input logic mf, input logic [7:0] clr);
    int c0, c1, fin;
    string rq;
    @(negedge clk);
    id_vld = v; id_pc = pc; id_undef = und; ex_ovf = ovf; mem_fault = mf; cause_clr = clr;
    #1;
    c0  = (v && und) ? 1 : 0;
    c1  = !m_vld[0] ? 0 : (m_code[0] != 0 ? m_code[0] : (ovf ? 2 : 0));
    fin = !m_vld[1] ? 0 : (m_code[1] != 0 ? m_code[1] : (mf ? 3 : 0));
    rq  = (fin == 1) ? "R2" : (fin == 2) ? "R3" : (fin == 3) ? "R4" : "R8";
    chk(rq, "redirect_vld", 32'(redirect_vld), 32'(fin != 0));
    chk("R7", "flush_front", 32'(flush_front), 32'(fin != 0));
    chk("R7", "mem_squash", 32'(mem_squash), 32'(fin != 0));
    if (fin != 0) chk(rq, "redirect_pc", redirect_pc, vec_of(fin));
    chk("R10", "epc", epc, m_epc);
    chk("R9", "cause", 32'(cause), 32'(m_cause));
    if (fin != 0) begin
      takes++;
      m_epc   = m_pc[1];
      m_cause = (m_cause & ~clr) | bit_of(fin);
      m_vld[0] = 1'b0; m_vld[1] = 1'b0; m_code[0] = 0; m_code[1] = 0;
    end else begin
      m_cause   = m_cause & ~clr;
      m_vld[1]  = m_vld[0]; m_pc[1] = m_pc[0]; m_code[1] = c1;
      m_vld[0]  = v;        m_pc[0] = pc;      m_code[0] = c0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int t0;
    void'($urandom(32'd20240611));
    m_vld[0] = 0; m_vld[1] = 0; m_pc[0] = 0; m_pc[1] = 0; m_code[0] = 0; m_code[1] = 0;
    m_epc = 0; m_cause = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    ctx = "reset";
    chk("R1", "redirect_vld", 32'(redirect_vld), 32'h0);
    chk("R1", "flush_front", 32'(flush_front), 32'h0);
    chk("R1", "epc", epc, 32'h0);
    chk("R1", "cause", 32'(cause), 32'h0);
    rst_n = 1'b1;

    ctx = "R2 undef";
    step(1, 32'h100, 1, 0, 0, 8'h00);
    step(1, 32'h104, 0, 0, 0, 8'h00);
    step(1, 32'h108, 0, 0, 0, 8'h00);
    idle(1);
    chk("R10", "epc after undef", epc, 32'h100);
    chk("R2", "cause after undef", 32'(cause), 32'h04);

    ctx = "R3 ovf";
    step(1, 32'h200, 0, 0, 0, 8'hFF);
    step(0, 32'h0, 0, 1, 0, 8'h00);
    step(0, 32'h0, 0, 0, 0, 8'h00);
    idle(1);
    chk("R3", "cause after ovf", 32'(cause), 32'h20);
    chk("R10", "epc after ovf", epc, 32'h200);

    ctx = "R4 memf";
    step(1, 32'h300, 0, 0, 0, 8'h00);
    step(0, 32'h0, 0, 0, 0, 8'h00);
    step(0, 32'h0, 0, 0, 1, 8'h00);
    idle(1);
    chk("R4", "cause after memf", 32'(cause), 32'h30);

    ctx = "R6 earliest";
    step(1, 32'h500, 1, 0, 0, 8'hFF);
    step(0, 32'h0, 0, 1, 0, 8'h00);
    step(0, 32'h0, 0, 0, 1, 8'h00);
    idle(1);
    chk("R6", "cause one instr three flags", 32'(cause), 32'h04);

    ctx = "R5 younger flushed";
    t0 = takes;
    step(1, 32'h400, 0, 0, 0, 8'hFF);
    step(1, 32'h404, 1, 1, 0, 8'h00);
    step(1, 32'h408, 1, 0, 0, 8'h00);
    idle(4);
    chk("R5", "takes for three faulting instrs", 32'(takes - t0), 32'd1);
    chk("R5", "cause only older fault", 32'(cause), 32'h20);
    chk("R5", "epc older instr", epc, 32'h400);

    ctx = "R8 bubbles";
    t0 = takes;
    step(0, 32'h600, 1, 0, 0, 8'h00);
    step(0, 32'h0, 0, 1, 0, 8'h00);
    step(0, 32'h0, 0, 0, 1, 8'h00);
    idle(2);
    chk("R8", "no take on bubbles", 32'(takes - t0), 32'd0);
    chk("R8", "cause untouched", 32'(cause), 32'h20);

    ctx = "R9 set beats clear";
    step(1, 32'h700, 0, 0, 0, 8'h00);
    step(0, 32'h0, 0, 1, 0, 8'h00);
    step(0, 32'h0, 0, 0, 0, 8'h20);
    idle(1);
    chk("R9", "set wins over clear", 32'(cause), 32'h20);

    ctx = "random";
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] clr;
      clr = (($urandom % 16) == 0) ? 8'($urandom) : 8'h00;
      step(($urandom % 5) != 0, 32'($urandom) & 32'hFFFF_FFFC,
           ($urandom % 12) == 0, ($urandom % 10) == 0, ($urandom % 12) == 0, clr);
    end
    idle(3);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule